// File: doc/BRIEF.md
# Synchronized Even-Ratio Output Divider Channel

This block is a bank of clock output channels for a clock fan-out device. A single distribution clock is picked from two reference inputs by one select bit, and every channel produces from it either the undivided clock or a clock divided by an even ratio. The ratio is twice an 8-bit code. A divided output has a 50% duty cycle and holds each level for `code` distribution cycles. A 2-bit path mode per channel decides whether the divider is in the path. The two delayed modes behave like their non-delayed counterparts, and they report the channel's delay code on a status output.

An active-low sync input aligns all divided channels. It is registered once and then passed through a fixed four-stage pipeline. While the pipelined sync is low, every divided output is held low and its counter is cleared. When the sync is released, all divided outputs rise on the same distribution edge and count from zero. Bypassed channels ignore sync.

Each output is driven only when three enables are all 1: its own channel enable, a global enable bit and a global enable pin. A powerdown bit turns every output off regardless of the other controls. A separate per-channel flag shows whether the output is driven. A channel in a divided mode with code 0 holds its output low and raises an error flag.

Top module: `even_div_fanout`

## Requirements
- R1: In a divided mode with code N (1..255), the output holds each level for exactly N distribution cycles, which gives a ratio of 2N. A code change takes effect without the counter getting stuck.
- R2: Path mode encoding: 0 is bypass, 1 is divided, 2 is delayed and 3 is divided plus delayed. Modes 0 and 2 pass the distribution clock. Modes 1 and 3 use the divider. The 4-bit delay status equals the channel's delay code in modes 2 and 3 and is 0 in modes 0 and 1.
- R3: A low on `sync_n` is captured at a distribution edge k. The divided outputs are forced low from edge k+4 onward, and they stay low while the captured value remains low.
- R4: A high on `sync_n` is captured at edge k. At edge k+4 all divided outputs with a nonzero code rise together. Each output then stays high for N cycles, counted from zero.
- R5: A channel in bypass or delayed mode keeps passing the distribution clock while sync is held low.
- R6: `out_driven[i]` is 1 only when `ch_en[i]`, `glb_en_bit` and `glb_en_pin` are all 1. Whenever `out_driven[i]` is 0, `clk_out[i]` is 0.
- R7: When `pwr_down` is 1, every `out_driven` bit and every `clk_out` bit is 0, whatever the state of the other controls.
- R8: When `sel_first` is 1 the distribution clock is `ref_clk0`. When it is 0 the distribution clock is `ref_clk1`.
- R9: A channel in mode 1 or 3 with code 0 holds its output low and sets `code_err[i]`. In modes 0 and 2, `code_err[i]` is 0 for any code.
- R10: While `rst_n` is low, every divided output is low and sync is not holding. The first divided level after reset is low, and it toggles after N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk0 | input | 1 | First reference clock |
| ref_clk1 | input | 1 | Second reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_first | input | 1 | 1 selects ref_clk0, 0 selects ref_clk1 |
| sync_n | input | 1 | Active-low alignment input, shared by all channels |
| glb_en_bit | input | 1 | Global output enable, control bit |
| glb_en_pin | input | 1 | Global output enable, pin |
| pwr_down | input | 1 | Powerdown, turns every output off |
| ch_mode | input | 2*NCH | Path mode per channel, 2 bits each |
| ch_code | input | 8*NCH | Divide code per channel (ratio = 2 x code) |
| ch_dly | input | 4*NCH | Delay code per channel, reported only |
| ch_en | input | NCH | Per-channel output enable |
| clk_out | output | NCH | Output clock level per channel |
| out_driven | output | NCH | 1 when the channel output is driven |
| code_err | output | NCH | Divided mode with code 0 |
| dly_status | output | 4*NCH | Delay code reported in delayed modes |

## Verification
A counter that skips or repeats a value stretches or shortens one half-period of the divided output. The next level change then lands on the wrong edge, typically within N cycles. A sync pipeline that is one stage too short or too long moves the forced low and the aligned rise by a cycle, and the bench sees this at the first edge after a sync transition. If any stage of the three-level enable or the powerdown is broken, the output shows a level or a driven flag in the very cycle the bad control is applied. A wrong clock select shows as a bypass level that does not follow the chosen reference at its own rising edges.

// File: rtl/even_div_pkg.sv
package even_div_pkg;

  localparam int MODE_W   = 2;
  localparam int SYNC_LAG = 4;

  typedef enum logic [MODE_W-1:0] {
    PATH_BYPASS  = 2'd0,
    PATH_DIV     = 2'd1,
    PATH_DLY     = 2'd2,
    PATH_DIV_DLY = 2'd3
  } path_e;

  function automatic logic path_divides(input logic [MODE_W-1:0] m);
    return (m == PATH_DIV) || (m == PATH_DIV_DLY);
  endfunction

  function automatic logic path_delays(input logic [MODE_W-1:0] m);
    return (m == PATH_DLY) || (m == PATH_DIV_DLY);
  endfunction

  function automatic logic chan_drive(input logic pd, input logic gbit,
                                      input logic gpin, input logic en);
    return !pd && gbit && gpin && en;
  endfunction

endpackage

// File: rtl/even_div_sync.sv
module even_div_sync
  import even_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic hold_o
);

  logic                cap_q;
  logic [SYNC_LAG-1:0] lag_q;
  logic [2:0]          age_q;

  // capture stage registers the pin; the lag chain adds the fixed delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b1;
      lag_q <= '1;
    end else begin
      cap_q <= sync_n;
      lag_q <= {lag_q[SYNC_LAG-2:0], cap_q};
    end
  end

  assign hold_o = !lag_q[SYNC_LAG-1];

  // edges since reset, saturating; lets the lag check look back safely
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
  end

  assert_sync_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd7) |-> (hold_o == !$past(sync_n, SYNC_LAG + 1)));

endmodule

// File: rtl/even_div_divider.sv
module even_div_divider #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              lvl_o,
  output logic              zero_o
);

  logic [CODE_W-1:0] cnt_q;
  logic              phase_q;
  logic              wrap;

  assign zero_o = (code_i == '0);
  assign wrap   = (cnt_q >= code_i - CODE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (zero_o) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= !phase_q;
    end else begin
      cnt_q   <= cnt_q + CODE_W'(1);
    end
  end

  assign lvl_o = phase_q && !hold_i && !zero_o;

  assert_release_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_i) && !zero_o) |-> lvl_o);

  assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_i) |-> (cnt_q == '0));

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_o && $stable(code_i)) |-> (cnt_q < code_i));

endmodule

// File: rtl/even_div_outstage.sv
module even_div_outstage
  import even_div_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic              dist_clk_i,
  input  logic              div_lvl_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              code_zero_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic              ch_en_i,
  input  logic              glb_bit_i,
  input  logic              glb_pin_i,
  input  logic              pwr_down_i,
  output logic              clk_o,
  output logic              drv_o,
  output logic              err_o,
  output logic [DLY_W-1:0]  dly_stat_o
);

  logic path_lvl;

  assign drv_o      = chan_drive(pwr_down_i, glb_bit_i, glb_pin_i, ch_en_i);
  assign path_lvl   = path_divides(mode_i) ? div_lvl_i : dist_clk_i;
  assign clk_o      = drv_o && path_lvl;
  assign err_o      = path_divides(mode_i) && code_zero_i;
  assign dly_stat_o = path_delays(mode_i) ? dly_i : '0;

endmodule

// File: rtl/even_div_fanout.sv
module even_div_fanout
  import even_div_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 8,
  parameter int DLY_W  = 4
) (
  input  logic                  ref_clk0,
  input  logic                  ref_clk1,
  input  logic                  rst_n,
  input  logic                  sel_first,
  input  logic                  sync_n,
  input  logic                  glb_en_bit,
  input  logic                  glb_en_pin,
  input  logic                  pwr_down,
  input  logic [MODE_W*NCH-1:0] ch_mode,
  input  logic [CODE_W*NCH-1:0] ch_code,
  input  logic [DLY_W*NCH-1:0]  ch_dly,
  input  logic [NCH-1:0]        ch_en,
  output logic [NCH-1:0]        clk_out,
  output logic [NCH-1:0]        out_driven,
  output logic [NCH-1:0]        code_err,
  output logic [DLY_W*NCH-1:0]  dly_status
);

  logic dist_clk;
  logic sync_hold;

  assign dist_clk = sel_first ? ref_clk0 : ref_clk1;

  even_div_sync u_sync (
    .clk    (dist_clk),
    .rst_n  (rst_n),
    .sync_n (sync_n),
    .hold_o (sync_hold)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic div_lvl;
    logic code_zero;

    even_div_divider #(.CODE_W(CODE_W)) u_div (
      .clk    (dist_clk),
      .rst_n  (rst_n),
      .hold_i (sync_hold),
      .code_i (ch_code[CODE_W*i +: CODE_W]),
      .lvl_o  (div_lvl),
      .zero_o (code_zero)
    );

    even_div_outstage #(.DLY_W(DLY_W)) u_out (
      .dist_clk_i  (dist_clk),
      .div_lvl_i   (div_lvl),
      .mode_i      (ch_mode[MODE_W*i +: MODE_W]),
      .code_zero_i (code_zero),
      .dly_i       (ch_dly[DLY_W*i +: DLY_W]),
      .ch_en_i     (ch_en[i]),
      .glb_bit_i   (glb_en_bit),
      .glb_pin_i   (glb_en_pin),
      .pwr_down_i  (pwr_down),
      .clk_o       (clk_out[i]),
      .drv_o       (out_driven[i]),
      .err_o       (code_err[i]),
      .dly_stat_o  (dly_status[DLY_W*i +: DLY_W])
    );

    assert_off_quiet_R6: assert property (@(posedge dist_clk) disable iff (!rst_n)
      !out_driven[i] |-> !clk_out[i]);

    assert_err_low_R9: assert property (@(posedge dist_clk) disable iff (!rst_n)
      code_err[i] |-> !clk_out[i]);

    assert_dly_quiet_R2: assert property (@(posedge dist_clk) disable iff (!rst_n)
      !ch_mode[MODE_W*i + 1] |-> (dly_status[DLY_W*i +: DLY_W] == '0));
  end

  assert_powerdown_R7: assert property (@(posedge dist_clk) disable iff (!rst_n)
    pwr_down |-> (out_driven == '0 && clk_out == '0));

endmodule

// File: tb/even_div_fanout_test.sv
`timescale 1ns/1ps
module even_div_fanout_test;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int DW  = 4;

  logic ref_clk0 = 1'b0;
  logic ref_clk1 = 1'b0;
  logic rst_n = 1'b0, sel_first = 1'b1, sync_n = 1'b1;
  logic gbit = 1'b1, gpin = 1'b1, pd = 1'b0;
  logic [2*NCH-1:0]  mode;
  logic [CW*NCH-1:0] code;
  logic [DW*NCH-1:0] dly;
  logic [NCH-1:0]    en;
  wire  [NCH-1:0]    clk_out, out_driven, code_err;
  wire  [DW*NCH-1:0] dly_status;

  even_div_fanout #(.NCH(NCH), .CODE_W(CW), .DLY_W(DW)) uut (
    .ref_clk0(ref_clk0), .ref_clk1(ref_clk1), .rst_n(rst_n), .sel_first(sel_first),
    .sync_n(sync_n), .glb_en_bit(gbit), .glb_en_pin(gpin), .pwr_down(pd),
    .ch_mode(mode), .ch_code(code), .ch_dly(dly), .ch_en(en),
    .clk_out(clk_out), .out_driven(out_driven), .code_err(code_err),
    .dly_status(dly_status)
  );

  // 125 MHz first reference, slower offset second reference
  always #4 ref_clk0 = ~ref_clk0;
  initial begin #3; forever #6 ref_clk1 = ~ref_clk1; end

  // the bench's own view of the chosen reference
  wire bclk = sel_first ? ref_clk0 : ref_clk1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // behavioural reference model
  int m_cnt[NCH];
  bit m_q[NCH];
  bit sq[$];

  function automatic int code_of(int i); return int'(code[CW*i +: CW]); endfunction
  function automatic int mode_of(int i); return int'(mode[2*i +: 2]);  endfunction
  function automatic int dly_of(int i);  return int'(dly[DW*i +: DW]);  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin m_cnt[i] = 0; m_q[i] = 1'b0; end
    sq.delete();
    repeat (5) sq.push_back(1'b1);
  endtask

  task automatic check(string tag, int ch, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s ch%0d %s actual=%0d expected=%0d at %0t", tag, ch, what, act, exp, $time);
    end
  endtask

  task automatic set_ch(int i, int m, int c, int d);
    mode[2*i +: 2]   = 2'(m);
    code[CW*i +: CW] = 8'(c);
    dly[DW*i +: DW]  = 4'(d);
  endtask

  task automatic run(int n, string tag);
    bit hold_old, hold_now, divides, drv;
    int c, lvl;
    repeat (n) begin
      @(posedge bclk);
      if (!rst_n) model_reset();
      else begin
        hold_old = !sq[0];
        for (int i = 0; i < NCH; i++) begin
          c = code_of(i);
          if (hold_old)              begin m_cnt[i] = 0; m_q[i] = 1'b1; end
          else if (c == 0)           begin m_cnt[i] = 0; m_q[i] = 1'b0; end
          else if (m_cnt[i] >= c-1)  begin m_cnt[i] = 0; m_q[i] = !m_q[i]; end
          else                       m_cnt[i]++;
        end
        sq.push_back(sync_n);
        void'(sq.pop_front());
      end
      #1;
      hold_now = !sq[0];
      for (int i = 0; i < NCH; i++) begin
        divides = (mode_of(i) == 1) || (mode_of(i) == 3);
        drv = !pd && gbit && gpin && en[i];
        // bypass level at 1 ns after the chosen reference rises is high
        lvl = divides ? int'(code_of(i) != 0 && !hold_now && m_q[i]) : 1;
        check(tag, i, "clk_out", int'(clk_out[i]), int'(drv) & lvl);
        check(tag, i, "out_driven", int'(out_driven[i]), int'(drv));
        check(tag, i, "code_err", int'(code_err[i]), int'(divides && code_of(i) == 0));
        check(tag, i, "dly_status", int'(dly_status[DW*i +: DW]),
              (mode_of(i) >= 2) ? dly_of(i) : 0);
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    en = '1;
    set_ch(0, 0, 1, 0);   // bypass
    set_ch(1, 1, 1, 0);   // divide by 2
    set_ch(2, 1, 2, 0);   // divide by 4
    set_ch(3, 3, 3, 5);   // divide by 6, delayed
    run(4, "R10");                       // reset state
    rst_n = 1'b1;
    run(24, "R1");                       // free-running ratios from reset
    sync_n = 1'b0; run(10, "R3");        // forced low after lag
    sync_n = 1'b1; run(30, "R4");        // aligned rise, restart count
    sync_n = 1'b0; run(3, "R5");         // bypass channel ignores sync
    set_ch(0, 2, 0, 9); run(6, "R5");    // delayed path also passes clock
    sync_n = 1'b1; run(10, "R2");
    set_ch(0, 0, 0, 9); run(4, "R2");    // status cleared in bypass
    en[1] = 1'b0; run(6, "R6");
    en[1] = 1'b1; gbit = 1'b0; run(6, "R6");
    gbit = 1'b1; gpin = 1'b0; run(6, "R6");
    gpin = 1'b1; run(4, "R6");
    pd = 1'b1; run(8, "R7");
    pd = 1'b0; run(4, "R7");
    set_ch(2, 1, 0, 0); run(8, "R9");    // divided with code 0
    set_ch(2, 0, 0, 0); run(4, "R9");    // bypass with code 0: no error
    set_ch(2, 3, 7, 2); set_ch(1, 1, 255, 0); run(1100, "R1");
    set_ch(1, 1, 4, 0); run(20, "R1");   // shrink code mid-count
    sync_n = 1'b0; run(8, "R3");
    sync_n = 1'b1; run(40, "R4");
    rst_n = 1'b0; sel_first = 1'b0; run(3, "R10");
    rst_n = 1'b1; run(40, "R8");         // second reference drives all paths
    done = 1'b1;
    summary();
    $finish;
  end
endmodule